// File: doc/BRIEF.md
# Legacy Memory Region Shadow Router

This block sits between a processor memory request port and three targets: main RAM, a device memory window, and a ROM port. It decodes every request that falls inside the first megabyte and names the target that should service it. Requests at or above 1 MB are forwarded to RAM untouched. The router also returns a forwarded address, which is relative to the target where the target is a window, and a shadow hit flag.

The upper ROM area at 0xC0000 to 0xFFFFF is split into fourteen segments. Each segment has a read steering bit and a write steering bit, held in seven 8-bit shadow-control registers. Firmware can copy a ROM image into the RAM underneath it, then enable reads from RAM while writes still reach the ROM port. Firmware can also open both directions. The registers are written and read through a plain register port.

The request path is a valid/ready stream with no storage. A response is valid in the same cycle as its request, and `req_ready` follows `rsp_ready` combinationally. A stalled consumer therefore stalls the producer with no added latency, and no request is dropped or duplicated. The target, forwarded address and hit flag are meaningful only while `rsp_valid` is high. They follow `req_addr` and `req_write` combinationally while a request is held.

Top module: `legacy_shadow_router`

## Requirements
- R1: A request address below 0xA0000 goes to RAM. The target code is 0, the forwarded address equals the request address, and the hit flag is 0.
- R2: A request address from 0xA0000 to 0xBFFFF goes to the device window. The target code is 1 and the forwarded address is the request address minus 0xA0000. No register setting changes this.
- R3: A request address at or above 0x100000 goes to RAM. The forwarded address is the full request address and the hit flag is 0.
- R4: In the ROM area (0xC0000 to 0xFFFFF), a request whose steering bit for its direction is clear goes to the ROM port. The target code is 2, the forwarded address is the request address minus 0xC0000, and the hit flag is 0.
- R5: In the ROM area, a read goes to RAM when its segment's bit 0 (read steer) is set. A write goes to RAM when its segment's bit 1 (write steer) is set. The two bits act independently. A request steered this way has target 0, forwarded address equal to the request address, and hit flag 1.
- R6: Registers 1 to 6 cover 0xC0000 to 0xEFFFF in ascending 16 KB segments, low nibble (bits 3:0) first, then high nibble (bits 7:4). In register 0, the low nibble covers 0xF0000 to 0xF7FFF and the high nibble covers 0xF8000 to 0xFFFFF.
- R7: Bits 3:2 and 7:6 of every register are reserved. They read back as zero and ignore writes.
- R8: A register write takes effect on the next rising clock edge. A request in the same cycle as the write is decoded with the old settings.
- R9: Reset clears all seven registers. After reset, a read of the reset vector 0xFFFF0 goes to the ROM port.
- R10: Reading a register index other than 0 to 6 returns zero. Writing such an index changes no register.
- R11: `rsp_valid` equals `req_valid` and `req_ready` equals `rsp_ready` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears the registers |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Routed request present |
| rsp_ready | input | 1 | Consumer accepts the routed request |
| rsp_target | output | 2 | 0 = RAM, 1 = device window, 2 = ROM port |
| rsp_addr | output | ADDR_W | Forwarded address |
| rsp_hit | output | 1 | ROM-area request redirected to RAM |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_idx` |

## Verification
The hardest case to reach from the ports is a ROM segment whose read and write steering disagree. It must be probed in both directions at its edge addresses, so that a swapped bit or an off-by-one segment index shows up. The bench first programs registers with asymmetric nibbles. It then walks a table of reads and writes on both sides of each programmed segment boundary. A register write and a request are also made in the same cycle, to show that the old setting applies until the edge.

// File: rtl/lmsr_pkg.sv
package lmsr_pkg;

  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_DEV = 2'd1,
    TGT_ROM = 2'd2
  } tgt_e;

  localparam int NUM_REGS   = 7;
  localparam int NUM_SEGS   = 2 * NUM_REGS;
  localparam int REG_IDX_W  = 3;
  localparam int SEG_IDX_W  = $clog2(NUM_SEGS);
  localparam int LEGACY_W   = 20;

  localparam logic [LEGACY_W-1:0] DEV_BASE = 20'hA0000;
  localparam logic [LEGACY_W-1:0] ROM_BASE = 20'hC0000;

endpackage

// File: rtl/lmsr_shadow_regs.sv
module lmsr_shadow_regs
  import lmsr_pkg::*;
#(
  parameter int NREG  = NUM_REGS,
  parameter int IDX_W = REG_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [2*NREG-1:0] rd_steer,
  output logic [2*NREG-1:0] wr_steer
);

  // steer[r][n] = {write steer, read steer} of nibble n of register r
  logic [NREG-1:0][1:0][1:0] steer;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        steer[r] <= '0;
      end else if (wr_en && idx == IDX_W'(r)) begin
        steer[r][0] <= wdata[1:0];
        steer[r][1] <= wdata[5:4];
      end
    end

    for (genvar n = 0; n < 2; n++) begin : g_nib
      assign rd_steer[2*r+n] = steer[r][n][0];
      assign wr_steer[2*r+n] = steer[r][n][1];
    end
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NREG; r++) begin
      if (idx == IDX_W'(r)) begin
        rdata = {2'b00, steer[r][1], 2'b00, steer[r][0]};
      end
    end
  end

endmodule

// File: rtl/lmsr_seg_select.sv
module lmsr_seg_select
  import lmsr_pkg::*;
(
  input  logic [LEGACY_W-1:0]  addr,
  output logic [SEG_IDX_W-1:0] seg
);

  // Flat segment index = register*2 + nibble.
  // 0xF0000..0xFFFFF -> register 0, nibble chosen by bit 15.
  // 0xC0000..0xEFFFF -> 16 KB slices, slice k maps to flat index k+2.
  logic [5:0] slice;

  always_comb begin
    slice = addr[19:14] - 6'h30;
    if (addr[19:16] == 4'hF) begin
      seg = SEG_IDX_W'(addr[15]);
    end else begin
      seg = SEG_IDX_W'(slice[3:0] + 4'd2);
    end
  end

endmodule

// File: rtl/lmsr_region_decode.sv
module lmsr_region_decode
  import lmsr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              seg_rd,
  input  logic              seg_wr,
  output tgt_e              target,
  output logic [ADDR_W-1:0] faddr,
  output logic              hit
);

  localparam int HI_W = ADDR_W - LEGACY_W;

  logic [LEGACY_W-1:0] low;
  logic                above;
  logic                in_dev;
  logic                in_rom;
  logic                steer;
  logic [LEGACY_W-1:0] dev_off;
  logic [LEGACY_W-1:0] rom_off;

  assign low     = addr[LEGACY_W-1:0];
  assign above   = |addr[ADDR_W-1:LEGACY_W];
  assign in_dev  = !above && (low[19:17] == 3'b101);
  assign in_rom  = !above && (low[19:18] == 2'b11);
  assign steer   = write ? seg_wr : seg_rd;
  assign dev_off = low - DEV_BASE;
  assign rom_off = low - ROM_BASE;

  always_comb begin
    target = TGT_RAM;
    faddr  = addr;
    hit    = 1'b0;
    if (in_dev) begin
      target = TGT_DEV;
      faddr  = {{HI_W{1'b0}}, dev_off};
    end else if (in_rom) begin
      if (steer) begin
        hit = 1'b1;
      end else begin
        target = TGT_ROM;
        faddr  = {{HI_W{1'b0}}, rom_off};
      end
    end
  end

endmodule

// File: rtl/legacy_shadow_router.sv
module legacy_shadow_router
  import lmsr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [1:0]           rsp_target,
  output logic [ADDR_W-1:0]    rsp_addr,
  output logic                 rsp_hit,
  input  logic                 reg_we,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata
);

  logic [NUM_SEGS-1:0]  rd_steer;
  logic [NUM_SEGS-1:0]  wr_steer;
  logic [SEG_IDX_W-1:0] seg;
  tgt_e                 target;

  lmsr_shadow_regs #(
    .NREG  (NUM_REGS),
    .IDX_W (REG_IDX_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_we),
    .idx      (reg_idx),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .rd_steer (rd_steer),
    .wr_steer (wr_steer)
  );

  lmsr_seg_select u_seg (
    .addr (req_addr[LEGACY_W-1:0]),
    .seg  (seg)
  );

  lmsr_region_decode #(
    .ADDR_W (ADDR_W)
  ) u_dec (
    .addr   (req_addr),
    .write  (req_write),
    .seg_rd (rd_steer[seg]),
    .seg_wr (wr_steer[seg]),
    .target (target),
    .faddr  (rsp_addr),
    .hit    (rsp_hit)
  );

  assign rsp_target = target;
  assign rsp_valid  = req_valid;
  assign req_ready  = rsp_ready;

endmodule

// File: rtl/lmsr_checker.sv
module lmsr_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_target,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_hit,
  input logic [2:0]        reg_idx,
  input logic [7:0]        reg_rdata
);

  logic below_mb;
  assign below_mb = (req_addr[ADDR_W-1:20] == '0);

  AST_LOW_TO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && below_mb && req_addr[19:0] < 20'hA0000
      |-> rsp_target == 2'd0 && rsp_addr == req_addr && !rsp_hit); // R1

  AST_VIDEO_NEVER_SHADOWED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && below_mb && req_addr[19:17] == 3'b101
      |-> rsp_target == 2'd1 && !rsp_hit); // R2

  AST_ABOVE_MB_TO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !below_mb |-> rsp_target == 2'd0 && rsp_addr == req_addr && !rsp_hit); // R3

  AST_ROM_UNLESS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && below_mb && req_addr[19:18] == 2'b11 && !rsp_hit
      |-> rsp_target == 2'd2); // R4

  AST_HIT_GOES_TO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_target == 2'd0 && rsp_addr == req_addr); // R5

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[3:2] == 2'b00 && reg_rdata[7:6] == 2'b00); // R7

  AST_BAD_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_idx == 3'd7 |-> reg_rdata == 8'h00); // R10

  AST_HANDSHAKE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == req_valid && req_ready == rsp_ready); // R11

endmodule

bind legacy_shadow_router lmsr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_target (rsp_target),
  .rsp_addr   (rsp_addr),
  .rsp_hit    (rsp_hit),
  .reg_idx    (reg_idx),
  .reg_rdata  (reg_rdata)
);

// File: tb/legacy_shadow_router_tb.sv
`timescale 1ns/1ps
module legacy_shadow_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_target;
  logic [31:0] rsp_addr;
  logic        rsp_hit;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  legacy_shadow_router u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_target(rsp_target), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // {write, addr, target, forwarded addr, hit}
  localparam int NV = 20;
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, 32'h00000000, 2'd0, 32'h00000000, 1'b0}, // R1
    {1'b1, 32'h0009FFFF, 2'd0, 32'h0009FFFF, 1'b0}, // R1
    {1'b0, 32'h000A0000, 2'd1, 32'h00000000, 1'b0}, // R2
    {1'b1, 32'h000BFFFF, 2'd1, 32'h0001FFFF, 1'b0}, // R2
    {1'b0, 32'h000C0010, 2'd0, 32'h000C0010, 1'b1}, // R5 reg1 low read
    {1'b1, 32'h000C0010, 2'd2, 32'h00000010, 1'b0}, // R5 reg1 low write to ROM
    {1'b0, 32'h000C4000, 2'd2, 32'h00004000, 1'b0}, // R5 reg1 high read to ROM
    {1'b1, 32'h000C4000, 2'd0, 32'h000C4000, 1'b1}, // R5 reg1 high write
    {1'b0, 32'h000C8000, 2'd2, 32'h00008000, 1'b0}, // R4 reg2 clear
    {1'b0, 32'h000D2345, 2'd0, 32'h000D2345, 1'b1}, // R6 reg3 low
    {1'b1, 32'h000D7FFF, 2'd0, 32'h000D7FFF, 1'b1}, // R6 reg3 high
    {1'b0, 32'h000D8000, 2'd2, 32'h00018000, 1'b0}, // R6 reg4 clear
    {1'b0, 32'h000EC000, 2'd0, 32'h000EC000, 1'b1}, // R6 reg6 high
    {1'b1, 32'h000EBFFF, 2'd2, 32'h0002BFFF, 1'b0}, // R6 reg6 low clear
    {1'b0, 32'h000F0000, 2'd0, 32'h000F0000, 1'b1}, // R6 reg0 low
    {1'b1, 32'h000F7FFF, 2'd0, 32'h000F7FFF, 1'b1}, // R6 reg0 low
    {1'b0, 32'h000FFFF0, 2'd0, 32'h000FFFF0, 1'b1}, // R6 reg0 high read
    {1'b1, 32'h000FFFF0, 2'd2, 32'h0003FFF0, 1'b0}, // R6 reg0 high write to ROM
    {1'b0, 32'h00100000, 2'd0, 32'h00100000, 1'b0}, // R3
    {1'b1, 32'hFFFFFFFF, 2'd0, 32'hFFFFFFFF, 1'b0}  // R3
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] idx, input logic [7:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_expect(input string req, input logic [2:0] idx, input logic [7:0] exp);
    @(negedge clk);
    reg_idx = idx;
    #1 check(req, {56'd0, reg_rdata}, {56'd0, exp});
  endtask

  task automatic route(input logic wr, input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state and reset vector
    for (int r = 0; r < 7; r++) reg_expect("R9 reset clear", 3'(r), 8'h00);
    route(1'b0, 32'h000FFFF0);
    check("R9 reset vector target", {62'd0, rsp_target}, 64'd2);
    check("R9 reset vector addr", {32'd0, rsp_addr}, 64'h3FFF0);

    // R11: handshake pass-through
    req_valid = 1'b0; rsp_ready = 1'b1; #1;
    check("R11 ready follows", {63'd0, req_ready}, 64'd1);
    check("R11 valid follows", {63'd0, rsp_valid}, 64'd0);
    rsp_ready = 1'b0; req_valid = 1'b1; #1;
    check("R11 stall", {62'd0, req_ready, rsp_valid}, 64'd1);
    rsp_ready = 1'b1;

    // program shadow registers
    reg_write(3'd0, 8'h13);
    reg_write(3'd1, 8'h21);
    reg_write(3'd3, 8'hFF);
    reg_write(3'd6, 8'h30);

    // R7: reserved bits
    reg_expect("R7 reserved reads zero", 3'd3, 8'h33);
    reg_expect("R7 readback reg1", 3'd1, 8'h21);

    // R10: out-of-range index
    reg_write(3'd7, 8'hFF);
    reg_expect("R10 bad index reads zero", 3'd7, 8'h00);
    reg_expect("R10 reg2 untouched", 3'd2, 8'h00);
    reg_expect("R10 reg4 untouched", 3'd4, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      route(VEC[i][67], VEC[i][66:35]);
      check($sformatf("R1-R6 vec%0d target", i), {62'd0, rsp_target}, {62'd0, VEC[i][34:33]});
      check($sformatf("R1-R6 vec%0d addr", i), {32'd0, rsp_addr}, {32'd0, VEC[i][32:1]});
      check($sformatf("R1-R6 vec%0d hit", i), {63'd0, rsp_hit}, {63'd0, VEC[i][0]});
    end

    // R2: video window unaffected by writing all registers
    for (int r = 0; r < 7; r++) reg_write(3'(r), 8'h33);
    route(1'b0, 32'h000B0000);
    check("R2 video under full shadow", {62'd0, rsp_target}, 64'd1);
    route(1'b0, 32'h000C0000);
    check("R5 full shadow read", {63'd0, rsp_hit}, 64'd1);
    for (int r = 0; r < 7; r++) reg_write(3'(r), 8'h00);

    // R8: same-cycle write uses old setting
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 3'd2; reg_wdata = 8'h01;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h000C8000;
    #1 check("R8 old setting same cycle", {62'd0, rsp_target}, 64'd2);
    @(negedge clk);
    reg_we = 1'b0;
    #1 check("R8 new setting next cycle", {62'd0, rsp_target}, 64'd0);
    check("R8 hit after edge", {63'd0, rsp_hit}, 64'd1);

    // R9: reset clears programmed registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    reg_expect("R9 reset clears reg2", 3'd2, 8'h00);
    route(1'b0, 32'h000FFFF0);
    check("R9 vector after re-reset", {62'd0, rsp_target}, 64'd2);

    req_valid = 1'b0;
    finish_run();
  end

endmodule